// File: doc/BRIEF.md
# Shift Count Sequencer

This block carries out the execute phase of a logical right-shift instruction over four timing steps, each signalled by its own strobe. In the first step a shift-amount register is loaded from the instruction's immediate field. In the second step that amount is replaced by the low bits of a register operand, but only if the immediate amount was zero. In the third step the value on the operand bus is shifted right by the amount, with zeros filling the top, and the shifted value is captured in a result register. In the fourth step the result is presented for writeback.

A single-cycle done pulse follows the writeback step, so the timing step generator knows it can return to its first step. The shifter handles every amount from zero to the data width minus one in a single step. An amount that is still zero after the second step gives an unshifted copy of the operand.

Top module: `shr_count_seq`

## Requirements
- R1: After reset, `shamt`, `result`, `wb_data` and `done` are zero and `wb_en` is low.
- R2: A legal strobe with bit 0 of `step_stb` set (count-load step) loads `shamt` from `imm_field` at that clock edge.
- R3: A legal strobe with bit 1 set (conditional-reload step) loads `shamt` from `opnd_bus[4:0]` if `shamt` is zero. If `shamt` is non-zero, it leaves `shamt` unchanged.
- R4: A legal strobe with bit 2 set (shift step) loads `result` with `opnd_bus` logically shifted right by `shamt`. The vacated top bits are zero.
- R5: If `shamt` is zero at the shift step, `result` becomes an exact copy of `opnd_bus`.
- R6: While a legal strobe with bit 3 set (writeback step) is applied, `wb_en` is high and `wb_data` equals `result`. At all other times `wb_en` is low.
- R7: `done` is high for exactly the one cycle after each writeback step.
- R8: A `step_stb` value with more than one bit set is ignored. `shamt` and `result` keep their values, `wb_en` stays low, and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_stb | input | 4 | Step strobes: bit0 count load, bit1 conditional reload, bit2 shift, bit3 writeback |
| imm_field | input | 5 | Immediate shift amount from the instruction |
| opnd_bus | input | 32 | Operand bus: register rc during reload, register rb during shift |
| shamt | output | 5 | Current shift amount |
| result | output | 32 | Shifted result register |
| wb_en | output | 1 | Writeback enable to the destination register |
| wb_data | output | 32 | Writeback value |
| done | output | 1 | End-of-sequence pulse |

## Verification
The hardest case to reach from the ports is the double-zero path. It needs a zero immediate, followed by a register operand whose low five bits are also zero, so the operand passes through unshifted. Random immediates seldom hit zero and random operands seldom have five clear low bits, so the stimulus forces a zero immediate in about a quarter of sequences and clears the operand's low bits in half of those. Directed sequences add the extreme amounts 1 and 31, a non-zero immediate that must override a register value, and multi-bit strobes in the middle of a sequence.

// File: rtl/shr_seq_pkg.sv
package shr_seq_pkg;
  localparam int NSTEP    = 4;
  localparam int STEP_CNT = 0;  // load amount from immediate
  localparam int STEP_RLD = 1;  // reload amount from register if zero
  localparam int STEP_SHF = 2;  // shift into result
  localparam int STEP_WB  = 3;  // write result back

  // Logical right shift of a 32-bit word, zero fill.
  function automatic logic [31:0] lsr32(input logic [31:0] v, input logic [4:0] n);
    return v >> n;
  endfunction
endpackage

// File: rtl/shr_count_reg.sv
module shr_count_reg #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_imm,
  input  logic             ld_reg,
  input  logic [CNT_W-1:0] imm,
  input  logic [CNT_W-1:0] reg_lo,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (ld_imm)
      cnt <= imm;
    else if (ld_reg && cnt_zero)
      cnt <= reg_lo;
  end
endmodule

// File: rtl/shr_barrel.sv
module shr_barrel #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = din;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH < DATA_W) begin : g_sh
      assign stage[k+1] = amt[k] ? {{SH{1'b0}}, stage[k][DATA_W-1:SH]} : stage[k];
    end else begin : g_clr
      assign stage[k+1] = amt[k] ? '0 : stage[k];
    end
  end

  assign dout = stage[CNT_W];
endmodule

// File: rtl/shr_out_stage.sv
module shr_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              wb_go,
  input  logic [DATA_W-1:0] shifted,
  output logic [DATA_W-1:0] result,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      if (capture) result <= shifted;
      done <= wb_go;
    end
  end

  assign wb_en   = wb_go;
  assign wb_data = wb_go ? result : '0;
endmodule

// File: rtl/shr_count_seq.sv
module shr_count_seq #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [shr_seq_pkg::NSTEP-1:0]   step_stb,
  input  logic [CNT_W-1:0]                imm_field,
  input  logic [DATA_W-1:0]               opnd_bus,
  output logic [CNT_W-1:0]                shamt,
  output logic [DATA_W-1:0]               result,
  output logic                            wb_en,
  output logic [DATA_W-1:0]               wb_data,
  output logic                            done
);
  import shr_seq_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              step_legal;
  logic              cnt_zero;
  logic [NSTEP-1:0]  step_go;
  logic [DATA_W-1:0] shifted;

  assign step_legal = $onehot(step_stb);
  assign step_go    = step_legal ? step_stb : '0;

  shr_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_imm   (step_go[STEP_CNT]),
    .ld_reg   (step_go[STEP_RLD]),
    .imm      (imm_field),
    .reg_lo   (opnd_bus[CNT_W-1:0]),
    .cnt      (shamt),
    .cnt_zero (cnt_zero)
  );

  shr_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
    .din  (opnd_bus),
    .amt  (shamt),
    .dout (shifted)
  );

  shr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (step_go[STEP_SHF]),
    .wb_go   (step_go[STEP_WB]),
    .shifted (shifted),
    .result  (result),
    .wb_en   (wb_en),
    .wb_data (wb_data),
    .done    (done)
  );
endmodule

// File: rtl/shr_count_seq_chk.sv
module shr_count_seq_chk #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        step_stb,
  input logic [CNT_W-1:0]  imm_field,
  input logic [DATA_W-1:0] opnd_bus,
  input logic [CNT_W-1:0]  shamt,
  input logic [DATA_W-1:0] result,
  input logic              wb_en,
  input logic [DATA_W-1:0] wb_data,
  input logic              done,
  input logic              step_legal,
  input logic              cnt_zero
);
  p_imm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_legal && step_stb[0]) |=> shamt == $past(imm_field));

  p_reload_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_legal && step_stb[1] && cnt_zero) |=> shamt == $past(opnd_bus[CNT_W-1:0]));

  p_reload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_legal && step_stb[1] && !cnt_zero) |=> $stable(shamt));

  p_top_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_legal && step_stb[2] && !cnt_zero) |=> !result[DATA_W-1]);

  p_zero_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_legal && step_stb[2] && cnt_zero) |=> result == $past(opnd_bus));

  p_wb_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data == result && step_stb == 4'b1000));

  p_done_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_legal && step_stb[3]) |=> done);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wb_en));

  p_multi_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_stb != 4'b0 && !step_legal) |=> ($stable(shamt) && $stable(result) && !done));
endmodule

bind shr_count_seq shr_count_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shr_count_seq_bench.sv
module shr_count_seq_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    step_stb;
  logic [4:0]    imm_field;
  logic [DW-1:0] opnd_bus;
  logic [4:0]    shamt;
  logic [DW-1:0] result;
  logic          wb_en;
  logic [DW-1:0] wb_data;
  logic          done;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench reference state
  logic [4:0]    m_cnt;
  logic [DW-1:0] m_res;

  shr_count_seq u_shr_count_seq (
    .clk(clk), .rst_n(rst_n), .step_stb(step_stb), .imm_field(imm_field),
    .opnd_bus(opnd_bus), .shamt(shamt), .result(result), .wb_en(wb_en),
    .wb_data(wb_data), .done(done)
  );

  always #5 clk = ~clk;

  // Bit-by-bit restatement of a zero-filling right shift.
  function automatic logic [DW-1:0] ref_shr(input logic [DW-1:0] v, input int n);
    logic [DW-1:0] o;
    for (int i = 0; i < DW; i++) o[i] = (i + n < DW) ? v[i+n] : 1'b0;
    return o;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one strobe for one clock; sample at the following falling edge.
  task automatic step(input logic [3:0] stb, input logic [4:0] imm, input logic [DW-1:0] bus);
    step_stb = stb; imm_field = imm; opnd_bus = bus;
    #1;
    if (stb == 4'b1000) begin
      check("R6 wb_en", {31'b0, wb_en}, 1);
      check("R6 wb_data", wb_data, m_res);
    end else begin
      check("R6 wb_en idle", {31'b0, wb_en}, 0);
    end
    @(negedge clk);
    step_stb = 4'b0;
  endtask

  task automatic run_seq(input logic [4:0] imm, input logic [DW-1:0] rc, input logic [DW-1:0] rb);
    step(4'b0001, imm, 32'hDEAD_BEEF);
    m_cnt = imm;
    check("R2 count load", {27'b0, shamt}, {27'b0, m_cnt});
    step(4'b0010, 5'h1F, rc);
    if (m_cnt == 0) m_cnt = rc[4:0];
    check("R3 reload", {27'b0, shamt}, {27'b0, m_cnt});
    step(4'b0100, 5'h0, rb);
    m_res = ref_shr(rb, int'(m_cnt));
    if (m_cnt == 0) check("R5 copy", result, rb);
    else            check("R4 shift", result, m_res);
    step(4'b1000, 5'h0, '0);
    check("R7 done high", {31'b0, done}, 1);
    @(negedge clk);
    check("R7 done low", {31'b0, done}, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0001));
    rst_n = 1'b0; step_stb = '0; imm_field = '0; opnd_bus = '0;
    m_cnt = '0; m_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 shamt", {27'b0, shamt}, 0);
    check("R1 result", result, 0);
    check("R1 wb_data", wb_data, 0);
    check("R1 wb_en", {31'b0, wb_en}, 0);
    check("R1 done", {31'b0, done}, 0);

    // Directed corners
    run_seq(5'd0, 32'h0000_0040, 32'hFFFF_FFFF);   // R5 double zero: copy
    run_seq(5'd0, 32'h0000_001F, 32'h8000_0000);   // R3 register amount 31
    run_seq(5'd1, 32'h0000_0007, 32'h8000_0001);   // R3 non-zero imm keeps 1
    run_seq(5'd31, 32'h0, 32'hF000_0000);           // R4 max amount

    // R8: multi-bit strobes in mid-sequence
    step(4'b0001, 5'd9, '0);
    m_cnt = 5'd9;
    step(4'b0101, 5'd3, 32'h1234_5678);
    check("R8 shamt held", {27'b0, shamt}, {27'b0, m_cnt});
    check("R8 result held", result, m_res);
    check("R8 no done", {31'b0, done}, 0);
    step(4'b1010, 5'd0, 32'h0);
    check("R8 wb ignored", {31'b0, done}, 0);
    check("R8 shamt held 2", {27'b0, shamt}, {27'b0, m_cnt});

    // Random sequences
    for (int t = 0; t < 300; t++) begin
      logic [4:0]    imm;
      logic [DW-1:0] rc, rb;
      imm = 5'($urandom);
      rc  = $urandom;
      rb  = $urandom;
      if ($urandom_range(3) == 0) begin
        imm = 5'd0;
        if ($urandom_range(1) == 0) rc[4:0] = 5'd0;
      end
      run_seq(imm, rc, rb);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule